// File: doc/BRIEF.md
# Flash Write Permission Guard

This block judges every CPU write or page-erase request aimed at an on-chip flash array and answers, one clock later, with a grant or a deny. Each request carries an operation type, a region code and a byte offset within that region. The regions are two large program blocks, one small data block and three 128-byte information blocks. Software programs three section write-enable registers through a simple write port. A short protection field is captured while reset is held and then stays fixed until the next reset. The field holds a global write-protect flag and the size of a boot area at the bottom of program block 0.

A granted erase also returns a one-hot-per-region mask of every region the erase wipes. Erasing an information block that has a paired main block also wipes that main block, and the mask shows both. Every denied request sets a sticky error flag. Software clears the flag by pulsing a clear input.

Top module: `flash_write_guard`

## Requirements
- R1: After reset, grant, deny, eraseMask and errFlag are 0, and all three write-enable registers are cleared, so every main-block request is denied.
- R2: protWordIn is sampled on every clock edge while rstN is low. Bit 0 becomes globalProtect and bits 4:1 become bootSections. Changes to protWordIn while rstN is high have no effect.
- R3: For program blocks 0 and 1 (region codes 0 and 1), the section is reqAddr[16:13]. A request is granted only if that bit is set in the block's write-enable register. weWrSel 0, 1 and 2 select the registers of regions 0, 1 and 2, and bit 0 is the lowest section.
- R4: For the data block (region 2), the section is reqAddr[12:9]. An offset of 2000h or above is denied.
- R5: In region 0, every write and erase to a section numbered below bootSections is denied, whatever its enable bit.
- R6: Information block 0 (region 3) is never granted, for writes or erases.
- R7: Information block 1 (region 4) is granted only when reqAddr[16:7] is 0, globalProtect is 0 and bit 0 of the region-1 enable register is set. This includes the protection field at offset 7Eh.
- R8: Information block 2 (region 5) is granted only when reqAddr[16:7] is 0 and globalProtect is 0.
- R9: One cycle after a cycle with reqValid high, exactly one of grant or deny is high for one cycle. Both are low otherwise. Region codes 6 and 7 are denied.
- R10: For a granted erase, eraseMask bit n is set for the target region code n. A region-4 erase also sets bit 1, and a region-5 erase also sets bit 2. Writes and denials give a zero mask.
- R11: errFlag goes high in the cycle deny is high and stays high. A cycle with errClr high and no deny clears it. When a deny and errClr arrive together, the flag ends high.
- R12: A write-enable register update in the same cycle as a request does not affect that request. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; protection field captured while low |
| protWordIn | input | 5 | Protection field: bit 0 global protect, bits 4:1 boot size |
| weWrEn | input | 1 | Write strobe for a write-enable register |
| weWrSel | input | 2 | Register select: 0 block 0, 1 block 1, 2 data block |
| weWrData | input | 16 | New register value, one bit per section |
| reqValid | input | 1 | Request present this cycle |
| reqErase | input | 1 | 1 = page erase, 0 = write |
| reqRegion | input | 3 | Target region code 0..5 |
| reqAddr | input | 17 | Byte offset within the region |
| errClr | input | 1 | Clear pulse for the error flag |
| grant | output | 1 | Request allowed (one cycle after request) |
| deny | output | 1 | Request refused (one cycle after request) |
| eraseMask | output | 6 | Regions wiped by a granted erase |
| errFlag | output | 1 | Sticky denial flag |
| globalProtect | output | 1 | Latched global protect flag |
| bootSections | output | 4 | Latched boot-area size in sections |

## Verification
The error flag has two writers that can act in the same cycle: a denied request sets it, and software's clear pulse resets it. The bench drives a request that must be refused in the same cycle as errClr, then checks the flag one cycle later. The flag must read 1, because the set wins. It also drives errClr alone and expects 0. A second collision, a write-enable register update in the same cycle as a request to that section, is judged by requiring the old value on that request and the new value on the next one.

// File: rtl/flashprot_pkg.sv
package flashprot_pkg;

  localparam int NUM_RGN = 6;

  typedef enum logic [2:0] {
    RGN_MAIN0 = 3'd0,
    RGN_MAIN1 = 3'd1,
    RGN_MAIN2 = 3'd2,
    RGN_INFO0 = 3'd3,
    RGN_INFO1 = 3'd4,
    RGN_INFO2 = 3'd5
  } region_e;

  // Strobes from the decision logic to the register side
  typedef struct packed {
    logic               grantStb;
    logic               denyStb;
    logic [NUM_RGN-1:0] wipeMask;
  } fpStrobe_t;

endpackage

// File: rtl/fp_ctrl.sv
module fp_ctrl
  import flashprot_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int MAIN_AW  = 17,
  parameter int MAIN2_AW = 13,
  parameter int INFO_AW  = 7
) (
  input  logic                        reqValid,
  input  logic                        reqErase,
  input  logic [2:0]                  reqRegion,
  input  logic [MAIN_AW-1:0]          reqAddr,
  input  logic [NUM_SECT-1:0]         weMain0,
  input  logic [NUM_SECT-1:0]         weMain1,
  input  logic [NUM_SECT-1:0]         weMain2,
  input  logic                        gwpOn,
  input  logic [$clog2(NUM_SECT)-1:0] bootSects,
  output fpStrobe_t                   strobe
);

  localparam int SECT_W = $clog2(NUM_SECT);

  logic [SECT_W-1:0]  secBig;
  logic [SECT_W-1:0]  secSmall;
  logic               main2InRange;
  logic               infoInRange;
  logic               inBoot;
  logic               allow;
  logic [NUM_RGN-1:0] hitMask;

  assign secBig       = reqAddr[MAIN_AW-1 -: SECT_W];
  assign secSmall     = reqAddr[MAIN2_AW-1 -: SECT_W];
  assign main2InRange = (reqAddr >> MAIN2_AW) == '0;
  assign infoInRange  = (reqAddr >> INFO_AW) == '0;
  assign inBoot       = secBig < bootSects;

  always_comb begin
    allow   = 1'b0;
    hitMask = '0;
    case (region_e'(reqRegion))
      RGN_MAIN0: begin
        allow   = weMain0[secBig] && !inBoot;
        hitMask = NUM_RGN'(1) << RGN_MAIN0;
      end
      RGN_MAIN1: begin
        allow   = weMain1[secBig];
        hitMask = NUM_RGN'(1) << RGN_MAIN1;
      end
      RGN_MAIN2: begin
        allow   = main2InRange && weMain2[secSmall];
        hitMask = NUM_RGN'(1) << RGN_MAIN2;
      end
      RGN_INFO0: begin
        allow   = 1'b0;
        hitMask = '0;
      end
      RGN_INFO1: begin
        allow   = infoInRange && !gwpOn && weMain1[0];
        hitMask = (NUM_RGN'(1) << RGN_INFO1) | (NUM_RGN'(1) << RGN_MAIN1);
      end
      RGN_INFO2: begin
        allow   = infoInRange && !gwpOn;
        hitMask = (NUM_RGN'(1) << RGN_INFO2) | (NUM_RGN'(1) << RGN_MAIN2);
      end
      default: begin
        allow   = 1'b0;
        hitMask = '0;
      end
    endcase
  end

  always_comb begin
    strobe.grantStb = reqValid && allow;
    strobe.denyStb  = reqValid && !allow;
    strobe.wipeMask = (reqValid && allow && reqErase) ? hitMask : '0;
  end

endmodule

// File: rtl/fp_datapath.sv
module fp_datapath
  import flashprot_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int NUM_WE   = 3,
  parameter int GWP_BIT  = 0,
  parameter int BOOT_LSB = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [BOOT_LSB+$clog2(NUM_SECT)-1:0] protWordIn,
  input  logic                        weWrEn,
  input  logic [$clog2(NUM_WE)-1:0]   weWrSel,
  input  logic [NUM_SECT-1:0]         weWrData,
  input  logic                        errClr,
  input  fpStrobe_t                   strobe,
  output logic [NUM_SECT-1:0]         weMain0,
  output logic [NUM_SECT-1:0]         weMain1,
  output logic [NUM_SECT-1:0]         weMain2,
  output logic                        gwpOn,
  output logic [$clog2(NUM_SECT)-1:0] bootSects,
  output logic                        grant,
  output logic                        deny,
  output logic [NUM_RGN-1:0]          eraseMask,
  output logic                        errFlag
);

  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int SEL_W  = $clog2(NUM_WE);

  logic [NUM_SECT-1:0] weBank [NUM_WE];

  // Section write-enable registers, one per main block
  for (genvar g = 0; g < NUM_WE; g++) begin : gWeBank
    always_ff @(posedge clk) begin
      if (!rstN)
        weBank[g] <= '0;
      else if (weWrEn && (weWrSel == SEL_W'(g)))
        weBank[g] <= weWrData;
    end
  end

  assign weMain0 = weBank[0];
  assign weMain1 = weBank[1];
  assign weMain2 = weBank[2];

  // Protection field: loaded only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gwpOn     <= protWordIn[GWP_BIT];
      bootSects <= protWordIn[BOOT_LSB +: SECT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant     <= 1'b0;
      deny      <= 1'b0;
      eraseMask <= '0;
    end else begin
      grant     <= strobe.grantStb;
      deny      <= strobe.denyStb;
      eraseMask <= strobe.wipeMask;
    end
  end

  // Sticky error: a new denial wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)
      errFlag <= 1'b0;
    else if (strobe.denyStb)
      errFlag <= 1'b1;
    else if (errClr)
      errFlag <= 1'b0;
  end

  AST_ERR_ON_DENY: assert property (@(posedge clk) disable iff (!rstN)
    deny |-> errFlag); // R11

  AST_DENY_NO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    deny |-> (eraseMask == '0)); // R10

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(gwpOn) && $stable(bootSects))); // R2

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !strobe.denyStb) |=> !errFlag); // R11

endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
  import flashprot_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int MAIN_AW  = 17,
  parameter int MAIN2_AW = 13,
  parameter int INFO_AW  = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [$clog2(NUM_SECT):0]   protWordIn,
  input  logic                        weWrEn,
  input  logic [1:0]                  weWrSel,
  input  logic [NUM_SECT-1:0]         weWrData,
  input  logic                        reqValid,
  input  logic                        reqErase,
  input  logic [2:0]                  reqRegion,
  input  logic [MAIN_AW-1:0]          reqAddr,
  input  logic                        errClr,
  output logic                        grant,
  output logic                        deny,
  output logic [NUM_RGN-1:0]          eraseMask,
  output logic                        errFlag,
  output logic                        globalProtect,
  output logic [$clog2(NUM_SECT)-1:0] bootSections
);

  localparam int SECT_W = $clog2(NUM_SECT);

  fpStrobe_t           strobe;
  logic [NUM_SECT-1:0] weMain0;
  logic [NUM_SECT-1:0] weMain1;
  logic [NUM_SECT-1:0] weMain2;

  fp_ctrl #(
    .NUM_SECT(NUM_SECT), .MAIN_AW(MAIN_AW),
    .MAIN2_AW(MAIN2_AW), .INFO_AW(INFO_AW)
  ) uCtrl (
    .reqValid (reqValid),
    .reqErase (reqErase),
    .reqRegion(reqRegion),
    .reqAddr  (reqAddr),
    .weMain0  (weMain0),
    .weMain1  (weMain1),
    .weMain2  (weMain2),
    .gwpOn    (globalProtect),
    .bootSects(bootSections),
    .strobe   (strobe)
  );

  fp_datapath #(
    .NUM_SECT(NUM_SECT), .NUM_WE(3), .GWP_BIT(0), .BOOT_LSB(1)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .protWordIn(protWordIn),
    .weWrEn   (weWrEn),
    .weWrSel  (weWrSel),
    .weWrData (weWrData),
    .errClr   (errClr),
    .strobe   (strobe),
    .weMain0  (weMain0),
    .weMain1  (weMain1),
    .weMain2  (weMain2),
    .gwpOn    (globalProtect),
    .bootSects(bootSections),
    .grant    (grant),
    .deny     (deny),
    .eraseMask(eraseMask),
    .errFlag  (errFlag)
  );

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (grant ^ deny)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!grant && !deny)); // R9

  AST_INFO0_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqRegion == 3'd3) |=> deny); // R6

  AST_BOOT_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqRegion == 3'd0 &&
     reqAddr[MAIN_AW-1 -: SECT_W] < bootSections) |=> deny); // R5

  AST_INFO2_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqErase && reqRegion == 3'd5 && !globalProtect &&
     (reqAddr >> INFO_AW) == '0) |=> (grant && eraseMask == 6'b100100)); // R10

endmodule

// File: tb/sim_flash_write_guard.sv
module sim_flash_write_guard;

  localparam int CLK_P = 10;
  localparam int NV    = 21;

  // {erase, region[2:0], addr[16:0], expGrant, expMask[5:0]}
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 3'd0, 17'h06000, 1'b1, 6'h00}, // R3 block0 sec3 enabled
    {1'b0, 3'd0, 17'h0A000, 1'b1, 6'h00}, // R3 block0 sec5
    {1'b0, 3'd0, 17'h10000, 1'b0, 6'h00}, // R3 block0 sec8 disabled
    {1'b0, 3'd0, 17'h02000, 1'b0, 6'h00}, // R5 sec1 inside boot
    {1'b1, 3'd0, 17'h04000, 1'b1, 6'h01}, // R5 sec2 first outside boot, R10
    {1'b1, 3'd0, 17'h00000, 1'b0, 6'h00}, // R5 erase sec0 refused
    {1'b0, 3'd1, 17'h00000, 1'b1, 6'h00}, // R3 block1 sec0
    {1'b0, 3'd1, 17'h02000, 1'b0, 6'h00}, // R3 block1 sec1 disabled
    {1'b1, 3'd2, 17'h00000, 1'b1, 6'h04}, // R4 data sec0 erase, R10
    {1'b0, 3'd2, 17'h01E00, 1'b1, 6'h00}, // R4 data sec15
    {1'b0, 3'd2, 17'h01C00, 1'b0, 6'h00}, // R4 data sec14 disabled
    {1'b0, 3'd2, 17'h02000, 1'b0, 6'h00}, // R4 beyond data block
    {1'b0, 3'd3, 17'h0007E, 1'b0, 6'h00}, // R6 info0 write
    {1'b1, 3'd3, 17'h00000, 1'b0, 6'h00}, // R6 info0 erase
    {1'b0, 3'd4, 17'h0007E, 1'b1, 6'h00}, // R7 protection field write
    {1'b1, 3'd4, 17'h00010, 1'b1, 6'h12}, // R7 R10 info1 erase pairs block1
    {1'b0, 3'd4, 17'h00080, 1'b0, 6'h00}, // R7 offset out of range
    {1'b1, 3'd5, 17'h00000, 1'b1, 6'h24}, // R8 R10 info2 erase pairs data
    {1'b0, 3'd5, 17'h0007F, 1'b1, 6'h00}, // R8 info2 write
    {1'b0, 3'd6, 17'h00000, 1'b0, 6'h00}, // R9 code 6
    {1'b0, 3'd7, 17'h00000, 1'b0, 6'h00}  // R9 code 7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  protWordIn = 5'h04;
  logic        weWrEn = 1'b0;
  logic [1:0]  weWrSel = 2'd0;
  logic [15:0] weWrData = 16'h0;
  logic        reqValid = 1'b0;
  logic        reqErase = 1'b0;
  logic [2:0]  reqRegion = 3'd0;
  logic [16:0] reqAddr = 17'h0;
  logic        errClr = 1'b0;
  logic        grant, deny, errFlag, globalProtect;
  logic [5:0]  eraseMask;
  logic [3:0]  bootSections;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_write_guard u0 (
    .clk(clk), .rstN(rstN), .protWordIn(protWordIn),
    .weWrEn(weWrEn), .weWrSel(weWrSel), .weWrData(weWrData),
    .reqValid(reqValid), .reqErase(reqErase), .reqRegion(reqRegion),
    .reqAddr(reqAddr), .errClr(errClr),
    .grant(grant), .deny(deny), .eraseMask(eraseMask), .errFlag(errFlag),
    .globalProtect(globalProtect), .bootSections(bootSections)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [4:0] pw);
    rstN = 1'b0;
    protWordIn = pw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setWe(input logic [1:0] sel, input logic [15:0] val);
    weWrEn = 1'b1; weWrSel = sel; weWrData = val;
    @(negedge clk);
    weWrEn = 1'b0;
  endtask

  // Drive at a falling edge; results are sampled at the next falling edge
  task automatic doReq(input logic er, input logic [2:0] rg, input logic [16:0] ad);
    reqValid = 1'b1; reqErase = er; reqRegion = rg; reqAddr = ad;
    @(negedge clk);
    reqValid = 1'b0; reqErase = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset(5'h04);
    // R1 reset state
    check("R1 grant", grant, 0);
    check("R1 deny", deny, 0);
    check("R1 eraseMask", eraseMask, 0);
    check("R1 errFlag", errFlag, 0);
    doReq(1'b0, 3'd0, 17'h10000);
    check("R1 cleared enables deny", deny, 1);
    // R2 latched field
    check("R2 globalProtect", globalProtect, 0);
    check("R2 bootSections", bootSections, 2);
    protWordIn = 5'h1F;
    repeat (2) @(negedge clk);
    check("R2 gwp ignores input", globalProtect, 0);
    check("R2 boot ignores input", bootSections, 2);
    // R11 clear alone
    check("R11 sticky", errFlag, 1);
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    check("R11 clear", errFlag, 0);

    setWe(2'd0, 16'h00FF);
    setWe(2'd1, 16'h0001);
    setWe(2'd2, 16'h8001);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      doReq(v[27], v[26:24], v[23:7]);
      check($sformatf("R9 vec%0d grant", i), grant, v[6]);
      check($sformatf("R9 vec%0d deny", i), deny, !v[6]);
      check($sformatf("R10 vec%0d mask", i), eraseMask, v[5:0]);
    end
    @(negedge clk);
    check("R9 pulse ends", grant | deny, 0);
    check("R2 field write no effect", bootSections, 2);

    // R11 deny and clear in the same cycle: set wins
    errClr = 1'b1;
    doReq(1'b0, 3'd3, 17'h0);
    errClr = 1'b0;
    check("R11 set beats clear", errFlag, 1);
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    check("R11 clear after", errFlag, 0);

    // R12 enable update coincident with request
    weWrEn = 1'b1; weWrSel = 2'd1; weWrData = 16'h0003;
    doReq(1'b0, 3'd1, 17'h02000);
    weWrEn = 1'b0;
    check("R12 old value used", deny, 1);
    doReq(1'b0, 3'd1, 17'h02000);
    check("R12 new value next", grant, 1);

    // Second reset: global protect on, boot covers 15 sections
    doReset(5'h1F);
    check("R2 gwp relatched", globalProtect, 1);
    check("R2 boot relatched", bootSections, 15);
    check("R1 errFlag after reset", errFlag, 0);
    setWe(2'd0, 16'hFFFF);
    setWe(2'd1, 16'hFFFF);
    doReq(1'b0, 3'd5, 17'h0);
    check("R8 protected info2", deny, 1);
    doReq(1'b1, 3'd4, 17'h0);
    check("R7 protected info1", deny, 1);
    check("R10 protected mask", eraseMask, 0);
    doReq(1'b0, 3'd0, 17'h1C000);
    check("R5 sec14 in boot", deny, 1);
    doReq(1'b1, 3'd0, 17'h1E000);
    check("R5 sec15 grant", grant, 1);
    check("R10 sec15 mask", eraseMask, 6'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule